// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external serial master (SPI mode 0, byte words, MSB first on the wire) read and write single bytes in a 14-bit address space that lives behind a plain synchronous register port. Each transaction inside one chip-select window begins with two command bytes. The first command byte holds a direction flag and the low seven address bits in reversed order. The second holds the high seven address bits, also reversed, and ends in one padding bit. A third byte then carries write data into the block, or read data back out to the master.

The serial pins are brought into the system clock domain by a synchroniser chain, and every edge is detected there. When a write byte completes, the block issues a one-cycle write strobe. When the second command byte of a read completes, it issues a one-cycle fetch strobe, so the response byte is loaded before the master needs its first bit. One address is served from inside the block: it returns a fixed identification byte and cannot be written. The reset input is expected to be asserted asynchronously and released in step with `clk`. The system clock must run at least eight times faster than SCLK.

Top module: `spi_regport_slave`

## Requirements
- R1: While reset is asserted and immediately after it, `miso`, `reg_we` and `reg_re` are 0.
- R2: A set bit 7 of the first command byte means read and a clear bit means write. Address bit k (k = 0..6) is taken from bit 6-k of the first byte. Address bit 7+k (k = 0..6) is taken from bit 7-k of the second byte. Bit 0 of the second byte has no effect.
- R3: A complete three-byte write produces exactly one `reg_we` pulse of one cycle, with `reg_addr` set to the decoded address and `reg_wdata` set to the third byte.
- R4: A read produces exactly one `reg_re` pulse of one cycle, with `reg_addr` set to the decoded address, once the second byte ends. During the third byte, the returned `reg_rdata` appears on `miso` MSB first. It changes after falling SCLK edges so that the master can sample it on rising edges.
- R5: A read of address `ID_ADDR` (default 0x0140) returns `ID_VALUE` (default 0x6B, upper five bits 0x68) without a `reg_re` pulse. A write to that address gives no `reg_we` pulse.
- R6: If chip select rises before the eighth bit of the third byte, no `reg_we` is issued. The next transaction is decoded from its own first bit.
- R7: Bytes after the third in one chip-select window issue no strobes, and `miso` stays 0 during them.
- R8: `miso` is 0 while chip select is high, during both command bytes, and during every byte of a write.
- R9: If chip select rises in the same cycle as the final rising SCLK edge of a write's data byte, the write is abandoned and no `reg_we` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sclk | input | 1 | Serial clock from master, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master, 0 when not returning read data |
| reg_addr | output | 14 | Decoded register address |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_we` |
| reg_re | output | 1 | One-cycle fetch strobe; data expected on `reg_rdata` one cycle later |
| reg_rdata | input | 8 | Read data from register storage |

## Verification
Two events can land in the same cycle: the end of a chip-select window and the detection of the last rising SCLK edge of a write data byte. Both pins pass through synchroniser chains of equal length. The bench therefore raises SCLK and chip select at the same instant, and both edges reach the edge detector together. The expected result is that the deselect wins: the write counter seen at the register port must not move. A following read of the same address must return the old contents.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  localparam int unsigned ADDR_W = 14;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LOW_BITS = DATA_W - 1;

  typedef enum logic [1:0] {
    PH_CMD0 = 2'd0,
    PH_CMD1 = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  // Low address bits sit reversed in byte 0 below the direction flag;
  // high address bits sit reversed in byte 1 above the padding bit.
  function automatic logic [ADDR_W-1:0] decode_addr(input logic [DATA_W-1:0] b0,
                                                    input logic [DATA_W-1:0] b1);
    logic [ADDR_W-1:0] a;
    for (int k = 0; k < int'(LOW_BITS); k++) begin
      a[k]            = b0[LOW_BITS-1-k];
      a[LOW_BITS + k] = b1[DATA_W-1-k];
    end
    return a;
  endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
  import spi_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              rd_go,
  output logic              wr_go,
  output logic              tx_en,
  output logic              tx_shift
);

  logic              sclk_q;
  logic [2:0]        bit_q, bit_nx;
  phase_e            ph_q, ph_nx;
  logic [DATA_W-1:0] sh_q, sh_nx;
  logic [DATA_W-1:0] b0_q, b0_nx;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic              rd_q, rd_nx;
  logic [DATA_W-1:0] wd_q, wd_nx;
  logic              rd_go_q, rd_go_nx;
  logic              wr_go_q, wr_go_nx;
  logic              rise, fall, byte_end;

  always_comb begin
    rise     = sclk_s & ~sclk_q & ~cs_n_s;
    fall     = ~sclk_s & sclk_q & ~cs_n_s;
    byte_end = rise && (bit_q == 3'd7) && (ph_q != PH_DONE);

    bit_nx   = bit_q;
    ph_nx    = ph_q;
    sh_nx    = sh_q;
    b0_nx    = b0_q;
    addr_nx  = addr_q;
    rd_nx    = rd_q;
    wd_nx    = wd_q;
    rd_go_nx = 1'b0;
    wr_go_nx = 1'b0;

    if (cs_n_s) begin
      bit_nx = 3'd0;
      ph_nx  = PH_CMD0;
    end else if (rise && (ph_q != PH_DONE)) begin
      sh_nx  = {sh_q[DATA_W-2:0], mosi_s};
      bit_nx = bit_q + 3'd1;
      if (byte_end) begin
        ph_nx = phase_e'(ph_q + 2'd1);
        case (ph_q)
          PH_CMD0: b0_nx = sh_nx;
          PH_CMD1: begin
            addr_nx  = decode_addr(b0_q, sh_nx);
            rd_nx    = b0_q[DATA_W-1];
            rd_go_nx = b0_q[DATA_W-1];
          end
          PH_DATA: begin
            if (!rd_q) begin
              wd_nx    = sh_nx;
              wr_go_nx = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      bit_q   <= 3'd0;
      ph_q    <= PH_CMD0;
      sh_q    <= '0;
      b0_q    <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      wd_q    <= '0;
      rd_go_q <= 1'b0;
      wr_go_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      bit_q   <= bit_nx;
      ph_q    <= ph_nx;
      sh_q    <= sh_nx;
      b0_q    <= b0_nx;
      addr_q  <= addr_nx;
      rd_q    <= rd_nx;
      wd_q    <= wd_nx;
      rd_go_q <= rd_go_nx;
      wr_go_q <= wr_go_nx;
    end
  end

  assign addr     = addr_q;
  assign wdata    = wd_q;
  assign rd_go    = rd_go_q;
  assign wr_go    = wr_go_q;
  assign tx_en    = ~cs_n_s & rd_q & (ph_q == PH_DATA);
  assign tx_shift = fall & (ph_q == PH_DATA) & (bit_q != 3'd0);

endmodule

// File: rtl/spi_regport_tx.sv
module spi_regport_tx
  import spi_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  input  logic              en,
  output logic              miso
);

  logic [DATA_W-1:0] tx_q, tx_nx;

  always_comb begin
    tx_nx = tx_q;
    if (load)       tx_nx = load_val;
    else if (shift) tx_nx = {tx_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_nx;
  end

  assign miso = en & tx_q[DATA_W-1];

endmodule

// File: rtl/spi_regport_slave.sv
module spi_regport_slave
  import spi_regport_pkg::*;
#(
  parameter logic [13:0] ID_ADDR     = 14'h0140,
  parameter logic [7:0]  ID_VALUE    = 8'h6B,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic [13:0] reg_addr,
  output logic        reg_we,
  output logic [7:0]  reg_wdata,
  output logic        reg_re,
  input  logic [7:0]  reg_rdata
);

  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic              rd_go, wr_go, tx_en, tx_shift;
  logic              ld_q, id_hit;
  logic [DATA_W-1:0] load_val;

  spi_regport_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sclk, mosi}),
    .q     (pins_s)
  );

  spi_regport_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (pins_s[1]),
    .cs_n_s   (pins_s[2]),
    .mosi_s   (pins_s[0]),
    .addr     (addr),
    .wdata    (wdata),
    .rd_go    (rd_go),
    .wr_go    (wr_go),
    .tx_en    (tx_en),
    .tx_shift (tx_shift)
  );

  assign id_hit = (addr == ID_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_q <= 1'b0;
    else        ld_q <= rd_go;
  end

  assign load_val = id_hit ? ID_VALUE : reg_rdata;

  spi_regport_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld_q),
    .load_val (load_val),
    .shift    (tx_shift),
    .en       (tx_en),
    .miso     (miso)
  );

  assign reg_addr  = addr;
  assign reg_wdata = wdata;
  assign reg_we    = wr_go & ~id_hit;
  assign reg_re    = rd_go & ~id_hit;

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter logic [13:0] ID_ADDR     = 14'h0140,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        miso,
  input logic        reg_we,
  input logic        reg_re,
  input logic [13:0] reg_addr
);

  localparam int unsigned CW = $clog2(SYNC_STAGES + 3) + 1;
  localparam logic [CW-1:0] IDLE_MIN = CW'(SYNC_STAGES + 1);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (!cs_n)             idle_cnt <= '0;
    else if (idle_cnt < IDLE_MIN) idle_cnt <= idle_cnt + 1'b1;
  end

  AST_WE_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n)
                    reg_we |=> !reg_we);                          // R3
  AST_RE_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n)
                    reg_re |=> !reg_re);                          // R4
  AST_DIR_EXCL:   assert property (@(posedge clk) disable iff (!rst_n)
                    !(reg_we && reg_re));                         // R2
  AST_ID_NO_WR:   assert property (@(posedge clk) disable iff (!rst_n)
                    reg_we |-> (reg_addr != ID_ADDR));            // R5
  AST_ID_NO_RD:   assert property (@(posedge clk) disable iff (!rst_n)
                    reg_re |-> (reg_addr != ID_ADDR));            // R5
  AST_MISO_IDLE:  assert property (@(posedge clk) disable iff (!rst_n)
                    (idle_cnt >= IDLE_MIN) |-> !miso);            // R8

endmodule

bind spi_regport_slave spi_regport_chk #(
  .ID_ADDR     (ID_ADDR),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .miso     (miso),
  .reg_we   (reg_we),
  .reg_re   (reg_re),
  .reg_addr (reg_addr)
);

// File: tb/spi_regport_slave_tb.sv
`timescale 1ns/1ps
module spi_regport_slave_tb;

  localparam int HALF = 8;
  localparam logic [13:0] ID_A = 14'h0140;
  localparam logic [7:0]  ID_V = 8'h6B;
  localparam int NV = 7;
  // {rw, pad, addr[13:0], data[7:0], expect[7:0]}
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 1'b0, 14'h0005, 8'hA5, 8'h00},
    {1'b0, 1'b1, 14'h2A13, 8'h3C, 8'h00},
    {1'b1, 1'b1, 14'h0005, 8'h00, 8'hA5},
    {1'b1, 1'b0, 14'h2A13, 8'h00, 8'h3C},
    {1'b1, 1'b0, 14'h0140, 8'h00, 8'h6B},
    {1'b0, 1'b0, 14'h3FFF, 8'h81, 8'h00},
    {1'b1, 1'b1, 14'h3FFF, 8'h00, 8'h81}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, reg_we, reg_re;
  logic [13:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata = 8'h00;

  logic [7:0]  mem [256];
  int          we_cnt = 0, re_cnt = 0;
  logic [13:0] we_addr = '0, re_addr = '0;
  logic [7:0]  we_data = '0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  spi_regport_slave u_dut (
    .clk (clk), .rst_n (rst_n), .sclk (sclk), .cs_n (cs_n), .mosi (mosi),
    .miso (miso), .reg_addr (reg_addr), .reg_we (reg_we),
    .reg_wdata (reg_wdata), .reg_re (reg_re), .reg_rdata (reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr[7:0]] <= reg_wdata;
      we_cnt  <= we_cnt + 1;
      we_addr <= reg_addr;
      we_data <= reg_wdata;
    end
    if (reg_re) begin
      reg_rdata <= mem[reg_addr[7:0]];
      re_cnt    <= re_cnt + 1;
      re_addr   <= reg_addr;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      rx[i] = miso;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  function automatic logic [7:0] cmd0(input logic rw, input logic [13:0] a);
    logic [7:0] b;
    b[7] = rw;
    for (int k = 0; k < 7; k++) b[6-k] = a[k];
    return b;
  endfunction

  function automatic logic [7:0] cmd1(input logic pad, input logic [13:0] a);
    logic [7:0] b;
    b[0] = pad;
    for (int k = 0; k < 7; k++) b[7-k] = a[7+k];
    return b;
  endfunction

  task automatic xfer(input logic rw, input logic pad, input logic [13:0] a,
                      input logic [7:0] d, output logic [7:0] r0,
                      output logic [7:0] r1, output logic [7:0] r2);
    cs_low();
    send_byte(cmd0(rw, a), r0);
    send_byte(cmd1(pad, a), r1);
    send_byte(d, r2);
    cs_high();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1, r2, r3;
    int w0, q0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 miso", {31'd0, miso}, 32'd0);
    check("R1 reg_we", {31'd0, reg_we}, 32'd0);
    check("R1 reg_re", {31'd0, reg_re}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {29'd0, miso, reg_we, reg_re}, 32'd0);

    // Vector table: R2 decode, R3 writes, R4 reads, R5 identity, R8 idle miso
    for (int v = 0; v < NV; v++) begin
      w0 = we_cnt; q0 = re_cnt;
      xfer(VEC[v][31], VEC[v][30], VEC[v][29:16], VEC[v][15:8], r0, r1, r2);
      check("R8 cmd bytes miso", {16'd0, r0, r1}, 32'd0);
      if (!VEC[v][31]) begin
        check("R3 write count", we_cnt - w0, 1);
        check("R2 write addr", {18'd0, we_addr}, {18'd0, VEC[v][29:16]});
        check("R3 write data", {24'd0, we_data}, {24'd0, VEC[v][15:8]});
        check("R8 write data byte miso", {24'd0, r2}, 32'd0);
      end else if (VEC[v][29:16] == ID_A) begin
        check("R5 id value", {24'd0, r2}, {24'd0, ID_V});
        check("R5 no fetch", re_cnt - q0, 0);
      end else begin
        check("R4 read data", {24'd0, r2}, {24'd0, VEC[v][7:0]});
        check("R4 fetch count", re_cnt - q0, 1);
        check("R2 read addr", {18'd0, re_addr}, {18'd0, VEC[v][29:16]});
      end
    end

    // R5: write to identity address ignored
    w0 = we_cnt;
    xfer(1'b0, 1'b0, ID_A, 8'h00, r0, r1, r2);
    check("R5 id write blocked", we_cnt - w0, 0);
    xfer(1'b1, 1'b0, ID_A, 8'h00, r0, r1, r2);
    check("R5 id unchanged", {24'd0, r2}, {24'd0, ID_V});

    // R6: short write aborted, then fresh decode
    w0 = we_cnt;
    cs_low();
    send_byte(cmd0(1'b0, 14'h0005), r0);
    send_byte(cmd1(1'b0, 14'h0005), r1);
    for (int i = 7; i >= 3; i--) begin
      mosi = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    cs_high();
    check("R6 partial write dropped", we_cnt - w0, 0);
    xfer(1'b1, 1'b0, 14'h0005, 8'h00, r0, r1, r2);
    check("R6 fresh decode after abort", {24'd0, r2}, 32'h0000_00A5);

    // R7: extra bytes ignored on write and read
    w0 = we_cnt;
    cs_low();
    send_byte(cmd0(1'b0, 14'h0033), r0);
    send_byte(cmd1(1'b1, 14'h0033), r1);
    send_byte(8'h5A, r2);
    send_byte(8'hC3, r3);
    cs_high();
    check("R7 one write only", we_cnt - w0, 1);
    check("R7 data is third byte", {24'd0, we_data}, 32'h0000_005A);
    q0 = re_cnt;
    cs_low();
    send_byte(cmd0(1'b1, 14'h0033), r0);
    send_byte(cmd1(1'b0, 14'h0033), r1);
    send_byte(8'hFF, r2);
    send_byte(8'hFF, r3);
    cs_high();
    check("R7 read data", {24'd0, r2}, 32'h0000_005A);
    check("R7 miso low after third byte", {24'd0, r3}, 32'd0);
    check("R7 one fetch only", re_cnt - q0, 1);

    // R9: deselect coincides with last data edge
    w0 = we_cnt;
    cs_low();
    send_byte(cmd0(1'b0, 14'h0005), r0);
    send_byte(cmd1(1'b0, 14'h0005), r1);
    for (int i = 7; i >= 1; i--) begin
      mosi = 1'b0;
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    mosi = 1'b0;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
    repeat (4*HALF) @(negedge clk);
    check("R9 write abandoned", we_cnt - w0, 0);
    check("R9 miso idle", {31'd0, miso}, 32'd0);
    xfer(1'b1, 1'b0, 14'h0005, 8'h00, r0, r1, r2);
    check("R9 old value kept", {24'd0, r2}, 32'h0000_00A5);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule